// File: doc/BRIEF.md
# Two-Class Interrupt Controller Register Block

This block collects 40 level-sensitive interrupt sources into two 32-bit banks. Sources 0 to 31 sit in bank 0, and sources 32 to 39 sit in the low bits of bank 1. Software uses a small synchronous register bus to program each source. It sets an enable bit, which is the mask, and a class bit that steers the source to either the fast interrupt line or the normal interrupt line. Software can read back the raw pending state and two filtered views, one per class.

A one-bit control register chooses how a halted core is woken. The wake can come from any pending source, or only from sources whose enable bit is set. The block also holds one priority entry per source, each a valid flag and a source id. It exposes all entries as a flat vector for an external highest-priority resolver. The resolver's result comes back in on an input port and is readable over the bus. All register state updates on the clock edge. The three outputs are combinational functions of that registered state and the halted input.

Top module: `dualclass_intc`

## Requirements
- R1: Source index i is held in bank i/32 at bit i%32. The raw pending word is read at offset 0x10 for bank 0 and at offset 0xAC for bank 1.
- R2: A pending bit takes the level of its source input at each rising clock edge. It is visible the cycle after the input changes and clears again when the input drops; it is never latched.
- R3: The enable (mask) words are at 0x04 and 0xA0 and the class words are at 0x08 and 0xA4, for bank 0 and bank 1. A class bit of 1 means the fast class. The normal view (0x00, 0x9C) reads pending AND enable AND NOT class. The fast view (0x0C, 0xA8) reads pending AND enable AND class.
- R4: `fiq_out` is high exactly when some source in either bank is pending, enabled and of the fast class.
- R5: `irq_out` is high exactly when some source in either bank is pending, enabled and of the normal class.
- R6: The control register at 0x14 stores bit 0 and reads back only that bit, with bits 31:1 reading zero. With bit 0 = 1, only enabled pending sources can wake a halted core. With bit 0 = 0, any pending source can wake it, whatever its enable bit.
- R7: `wake_out` is low whenever `core_halted` is low.
- R8: Priority entries 0 to 31 sit at 0x1C + 4k and entries 32 to 39 at 0xB0 + 4(k-32). A write keeps only bit 31, the valid flag, and bits 5:0, the source id. All other bits read back as zero. Entry k appears on `prio_table[7k+6:7k]` as {valid, id}.
- R9: Writes to the pending views, the raw pending words, the result register and unmapped offsets change no stored state. Reads of unmapped or non-word-aligned offsets return zero.
- R10: Reset clears the pending, enable and class words of both banks, the control register and every priority entry.
- R11: A read of offset 0x18 returns the value on `hp_result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| src_in | input | 40 | Level interrupt source inputs |
| core_halted | input | 1 | High while the core is halted |
| hp_result | input | 32 | Result word from the external priority resolver |
| prio_table | output | 280 | All priority entries, 7 bits each, entry 0 lowest |
| fiq_out | output | 1 | Fast-class interrupt request |
| irq_out | output | 1 | Normal-class interrupt request |
| wake_out | output | 1 | Wake request for a halted core |

## Verification
The assertions check several properties on every cycle. Pending tracks the source level one edge later, and enable and class words hold unless their own write strobe fires. A priority write stores exactly the valid flag and id. The two request outputs agree with the per-class views, wake never rises without the halt input, and control and unmapped reads never show stray bits. Other behaviours can only be shown by the bench's directed scenarios. These are the address placement of each bank and each priority entry, the bit-for-bit content of the views for chosen mask and class patterns, the difference between the two wake policies, and the fact that writes to read-only offsets leave the programmed state intact.

// File: rtl/dcintc_pkg.sv
`timescale 1ns/1ps
package dcintc_pkg;

    // Register offsets (byte addresses)
    localparam int OFF_NVIEW0 = 'h00;
    localparam int OFF_MASK0  = 'h04;
    localparam int OFF_CLASS0 = 'h08;
    localparam int OFF_FVIEW0 = 'h0C;
    localparam int OFF_RAW0   = 'h10;
    localparam int OFF_CTRL   = 'h14;
    localparam int OFF_HPRES  = 'h18;
    localparam int OFF_PRIO_L = 'h1C;
    localparam int OFF_NVIEW1 = 'h9C;
    localparam int OFF_MASK1  = 'hA0;
    localparam int OFF_CLASS1 = 'hA4;
    localparam int OFF_FVIEW1 = 'hA8;
    localparam int OFF_RAW1   = 'hAC;
    localparam int OFF_PRIO_H = 'hB0;

    // Entries reachable from the low priority window
    localparam int PRIO_L_COUNT = 32;

    typedef enum logic [3:0] {
        K_NONE,
        K_NVIEW,
        K_MASK,
        K_CLASS,
        K_FVIEW,
        K_RAW,
        K_CTRL,
        K_HPRES,
        K_PRIO
    } reg_kind_e;

    typedef struct packed {
        logic only_unmasked;
    } ctrl_st_t;

endpackage

// File: rtl/dcintc_decode.sv
`timescale 1ns/1ps
module dcintc_decode
    import dcintc_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int NUM_SRC = 40,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic              bank,
    output logic [IDX_W-1:0]  prio_idx
);

    localparam int HI_COUNT = NUM_SRC - PRIO_L_COUNT;
    localparam int LO_LAST  = OFF_PRIO_L + 4 * (PRIO_L_COUNT - 1);
    localparam int HI_LAST  = OFF_PRIO_H + 4 * (HI_COUNT - 1);

    int a;

    always_comb begin
        a        = int'(addr);
        kind     = K_NONE;
        bank     = 1'b0;
        prio_idx = '0;
        if (addr[1:0] == 2'b00) begin
            case (a)
                OFF_NVIEW0: kind = K_NVIEW;
                OFF_MASK0:  kind = K_MASK;
                OFF_CLASS0: kind = K_CLASS;
                OFF_FVIEW0: kind = K_FVIEW;
                OFF_RAW0:   kind = K_RAW;
                OFF_CTRL:   kind = K_CTRL;
                OFF_HPRES:  kind = K_HPRES;
                OFF_NVIEW1: begin kind = K_NVIEW; bank = 1'b1; end
                OFF_MASK1:  begin kind = K_MASK;  bank = 1'b1; end
                OFF_CLASS1: begin kind = K_CLASS; bank = 1'b1; end
                OFF_FVIEW1: begin kind = K_FVIEW; bank = 1'b1; end
                OFF_RAW1:   begin kind = K_RAW;   bank = 1'b1; end
                default: begin
                    if (a >= OFF_PRIO_L && a <= LO_LAST) begin
                        kind     = K_PRIO;
                        prio_idx = IDX_W'((a - OFF_PRIO_L) / 4);
                    end else if (HI_COUNT > 0 && a >= OFF_PRIO_H && a <= HI_LAST) begin
                        kind     = K_PRIO;
                        prio_idx = IDX_W'(PRIO_L_COUNT + (a - OFF_PRIO_H) / 4);
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/dcintc_bank.sv
`timescale 1ns/1ps
module dcintc_bank #(
    parameter int W     = 32,
    parameter int SRC_N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic         wr_mask,
    input  logic         wr_class,
    input  logic [W-1:0] wdata,
    input  logic         wake_any,
    output logic [W-1:0] pend,
    output logic [W-1:0] mask,
    output logic [W-1:0] cls,
    output logic [W-1:0] fview,
    output logic [W-1:0] nview,
    output logic         any_fast,
    output logic         any_norm,
    output logic         wake_hit
);

    localparam logic [W-1:0] VALID = {W{1'b1}} >> (W - SRC_N);

    typedef struct packed {
        logic [W-1:0] pend;
        logic [W-1:0] mask;
        logic [W-1:0] cls;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = src & VALID;
        if (wr_mask)  st_d.mask = wdata;
        if (wr_class) st_d.cls  = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic [W-1:0] live;
    logic [W-1:0] wake_src;

    always_comb begin
        live     = st_q.pend & st_q.mask;
        fview    = live & st_q.cls;
        nview    = live & ~st_q.cls;
        any_fast = |fview;
        any_norm = |nview;
        wake_src = wake_any ? st_q.pend : live;
        wake_hit = |wake_src;
        pend     = st_q.pend;
        mask     = st_q.mask;
        cls      = st_q.cls;
    end

    AST_PEND_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pend == ($past(src) & VALID)));                       // R2
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mask |=> $stable(mask));                                     // R9
    AST_CLASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_class |=> $stable(cls));                                     // R9

endmodule

// File: rtl/dcintc_prio.sv
`timescale 1ns/1ps
module dcintc_prio #(
    parameter int NUM_SRC = 40,
    parameter int ID_W    = 6,
    parameter int IDX_W   = $clog2(NUM_SRC),
    parameter int ENT_W   = ID_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr,
    input  logic [IDX_W-1:0]           idx,
    input  logic                       wr_valid,
    input  logic [ID_W-1:0]            wr_id,
    output logic [31:0]                rd_word,
    output logic [NUM_SRC*ENT_W-1:0]   table_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0]           valid;
        logic [NUM_SRC-1:0][ID_W-1:0] id;
    } prio_st_t;

    prio_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.valid[idx] = wr_valid;
            st_d.id[idx]    = wr_id;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_word = {st_q.valid[idx], {(31 - ID_W){1'b0}}, st_q.id[idx]};

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_tab
        assign table_o[k*ENT_W +: ENT_W] = {st_q.valid[k], st_q.id[k]};
    end

    AST_PRIO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (st_q.valid[$past(idx)] == $past(wr_valid))
            && (st_q.id[$past(idx)] == $past(wr_id)));                   // R8

endmodule

// File: rtl/dualclass_intc.sv
`timescale 1ns/1ps
module dualclass_intc
    import dcintc_pkg::*;
#(
    parameter int NUM_SRC = 40,
    parameter int BANK_W  = 32,
    parameter int ID_W    = 6,
    parameter int ADDR_W  = 8,
    parameter int NB      = (NUM_SRC + BANK_W - 1) / BANK_W,
    parameter int IDX_W   = $clog2(NUM_SRC),
    parameter int ENT_W   = ID_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_we,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    input  logic [NUM_SRC-1:0]       src_in,
    input  logic                     core_halted,
    input  logic [31:0]              hp_result,
    output logic [NUM_SRC*ENT_W-1:0] prio_table,
    output logic                     fiq_out,
    output logic                     irq_out,
    output logic                     wake_out
);

    // Address decode
    reg_kind_e        kind;
    logic             dec_bank;
    logic [IDX_W-1:0] prio_idx;

    dcintc_decode #(
        .ADDR_W  (ADDR_W),
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) u_dec (
        .addr     (bus_addr),
        .kind     (kind),
        .bank     (dec_bank),
        .prio_idx (prio_idx)
    );

    // Control register
    ctrl_st_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (bus_we && kind == K_CTRL) ctrl_d.only_unmasked = bus_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    // Banks
    logic [NB*BANK_W-1:0]       src_pad;
    logic [NB-1:0][BANK_W-1:0]  pend_b, mask_b, cls_b, fview_b, nview_b;
    logic [NB-1:0]              fast_b, norm_b, wake_b;

    always_comb begin
        src_pad                = '0;
        src_pad[NUM_SRC-1:0]   = src_in;
    end

    for (genvar b = 0; b < NB; b++) begin : g_bank
        localparam int REM   = NUM_SRC - b * BANK_W;
        localparam int SRC_N = (REM >= BANK_W) ? BANK_W : REM;

        logic wr_mask_b, wr_class_b;
        assign wr_mask_b  = bus_we && kind == K_MASK  && int'(dec_bank) == b;
        assign wr_class_b = bus_we && kind == K_CLASS && int'(dec_bank) == b;

        dcintc_bank #(
            .W     (BANK_W),
            .SRC_N (SRC_N)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .src      (src_pad[b*BANK_W +: BANK_W]),
            .wr_mask  (wr_mask_b),
            .wr_class (wr_class_b),
            .wdata    (bus_wdata[BANK_W-1:0]),
            .wake_any (!ctrl_q.only_unmasked),
            .pend     (pend_b[b]),
            .mask     (mask_b[b]),
            .cls      (cls_b[b]),
            .fview    (fview_b[b]),
            .nview    (nview_b[b]),
            .any_fast (fast_b[b]),
            .any_norm (norm_b[b]),
            .wake_hit (wake_b[b])
        );
    end

    // Priority entries
    logic [31:0] prio_rd;

    dcintc_prio #(
        .NUM_SRC (NUM_SRC),
        .ID_W    (ID_W),
        .IDX_W   (IDX_W),
        .ENT_W   (ENT_W)
    ) u_prio (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_we && kind == K_PRIO),
        .idx      (prio_idx),
        .wr_valid (bus_wdata[31]),
        .wr_id    (bus_wdata[ID_W-1:0]),
        .rd_word  (prio_rd),
        .table_o  (prio_table)
    );

    // Read mux
    always_comb begin
        bus_rdata = '0;
        case (kind)
            K_NVIEW: bus_rdata = 32'(nview_b[dec_bank]);
            K_MASK:  bus_rdata = 32'(mask_b[dec_bank]);
            K_CLASS: bus_rdata = 32'(cls_b[dec_bank]);
            K_FVIEW: bus_rdata = 32'(fview_b[dec_bank]);
            K_RAW:   bus_rdata = 32'(pend_b[dec_bank]);
            K_CTRL:  bus_rdata = {31'b0, ctrl_q.only_unmasked};
            K_HPRES: bus_rdata = hp_result;
            K_PRIO:  bus_rdata = prio_rd;
            default: bus_rdata = '0;
        endcase
    end

    // Outputs
    always_comb begin
        fiq_out  = |fast_b;
        irq_out  = |norm_b;
        wake_out = core_halted && (|wake_b);
    end

    AST_WAKE_NEEDS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        wake_out |-> core_halted);                                       // R7
    AST_FIQ_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_out == (|fview_b));                                          // R4
    AST_IRQ_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (|nview_b));                                          // R5
    AST_CTRL_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_CTRL) |-> (bus_rdata[31:1] == 31'b0));                // R6
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_NONE) |-> (bus_rdata == 32'b0));                      // R9
    AST_MASKED_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.only_unmasked && !fiq_out && !irq_out) |-> !wake_out);   // R6

endmodule

// File: tb/sim_dualclass_intc.sv
`timescale 1ns/1ps
module sim_dualclass_intc;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic         bus_we = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [39:0]  src_in = '0;
    logic         core_halted = 1'b0;
    logic [31:0]  hp_result = '0;
    logic [279:0] prio_table;
    logic         fiq_out, irq_out, wake_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    dualclass_intc u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_we      (bus_we),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .src_in      (src_in),
        .core_halted (core_halted),
        .hp_result   (hp_result),
        .prio_table  (prio_table),
        .fiq_out     (fiq_out),
        .irq_out     (irq_out),
        .wake_out    (wake_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic set_src(input logic [39:0] s);
        @(negedge clk);
        src_in = s;
        @(negedge clk);
    endtask

    task automatic clean();
        set_src('0);
        wr(8'h04, 0); wr(8'hA0, 0); wr(8'h08, 0); wr(8'hA4, 0); wr(8'h14, 0);
    endtask

    task automatic t_reset();
        rd_chk("R10 mask0", 8'h04, 0);
        rd_chk("R10 mask1", 8'hA0, 0);
        rd_chk("R10 class0", 8'h08, 0);
        rd_chk("R10 raw0", 8'h10, 0);
        rd_chk("R10 ctrl", 8'h14, 0);
        rd_chk("R10 prio0", 8'h1C, 0);
        chk("R10 outputs", {29'b0, fiq_out, irq_out, wake_out}, 0);
    endtask

    task automatic t_mapping();
        logic [31:0] v;
        @(negedge clk);
        src_in = 40'h08_0000_0020;          // sources 5 and 35
        bus_addr = 8'h10;
        #1 chk("R2 not yet visible", bus_rdata, 0);
        @(negedge clk);
        rd_chk("R1 raw bank0", 8'h10, 32'h20);
        rd_chk("R1 raw bank1", 8'hAC, 32'h08);
        @(negedge clk);
        src_in = '0;
        @(negedge clk);
        rd(8'h10, v);
        chk("R2 cleared on low", v, 0);
    endtask

    task automatic t_views();
        clean();
        set_src(40'h03_0000_00F0);
        wr(8'h04, 32'hF0); wr(8'h08, 32'hA0);
        wr(8'hA0, 32'h3);  wr(8'hA4, 32'h1);
        rd_chk("R3 normal0", 8'h00, 32'h50);
        rd_chk("R3 fast0",   8'h0C, 32'hA0);
        rd_chk("R3 normal1", 8'h9C, 32'h2);
        rd_chk("R3 fast1",   8'hA8, 32'h1);
        rd_chk("R3 mask0",   8'h04, 32'hF0);
        rd_chk("R3 class1",  8'hA4, 32'h1);
        chk("R4 fiq both", {31'b0, fiq_out}, 1);
        chk("R5 irq both", {31'b0, irq_out}, 1);
        wr(8'h04, 32'h20); wr(8'hA0, 32'h0);
        chk("R4 fiq only", {31'b0, fiq_out}, 1);
        chk("R5 irq off",  {31'b0, irq_out}, 0);
        wr(8'h04, 32'h10);
        chk("R4 fiq off",  {31'b0, fiq_out}, 0);
        chk("R5 irq only", {31'b0, irq_out}, 1);
        wr(8'hA0, 32'h1);                   // source 32, fast class
        chk("R4 fiq from bank1", {31'b0, fiq_out}, 1);
        wr(8'h04, 0); wr(8'hA0, 0);
        chk("R4 R5 all masked", {30'b0, fiq_out, irq_out}, 0);
    endtask

    task automatic t_wake();
        clean();
        set_src(40'h1_0000_0000);           // source 32 pending, masked
        @(negedge clk);
        chk("R7 not halted", {31'b0, wake_out}, 0);
        core_halted = 1'b1;
        #1 chk("R6 any pending wakes", {31'b0, wake_out}, 1);
        wr(8'h14, 32'hFFFF_FFFF);
        rd_chk("R6 ctrl readback", 8'h14, 1);
        chk("R6 masked no wake", {31'b0, wake_out}, 0);
        wr(8'hA0, 32'h1);
        chk("R6 unmasked wakes", {31'b0, wake_out}, 1);
        @(negedge clk);
        core_halted = 1'b0;
        #1 chk("R7 halt dropped", {31'b0, wake_out}, 0);
        wr(8'h14, 32'h0000_0002);
        rd_chk("R6 ctrl bit0 only", 8'h14, 0);
    endtask

    task automatic t_prio();
        wr(8'h1C, 32'hFFFF_FFFF);
        rd_chk("R8 entry0", 8'h1C, 32'h8000_003F);
        wr(8'h98, 32'h1234_5678);
        rd_chk("R8 entry31", 8'h98, 32'h0000_0038);
        wr(8'hB0, 32'h8000_0011);
        rd_chk("R8 entry32", 8'hB0, 32'h8000_0011);
        wr(8'hCC, 32'hC0FF_EEA7);
        rd_chk("R8 entry39", 8'hCC, 32'h8000_0027);
        chk("R8 table39", {25'b0, prio_table[39*7 +: 7]}, 32'h67);
        chk("R8 table0",  {25'b0, prio_table[6:0]},       32'h7F);
        chk("R8 table31", {25'b0, prio_table[31*7 +: 7]}, 32'h38);
    endtask

    task automatic t_readonly();
        clean();
        set_src(40'h5);
        wr(8'h04, 32'h1);
        wr(8'h00, '1); wr(8'h0C, '1); wr(8'h10, '1); wr(8'h18, '1);
        wr(8'h9C, '1); wr(8'hA8, '1); wr(8'hAC, '1); wr(8'hD0, '1);
        rd_chk("R9 mask0 kept",  8'h04, 32'h1);
        rd_chk("R9 class0 kept", 8'h08, 0);
        rd_chk("R9 mask1 kept",  8'hA0, 0);
        rd_chk("R9 raw0 kept",   8'h10, 32'h5);
        rd_chk("R9 ctrl kept",   8'h14, 0);
        rd_chk("R9 prio kept",   8'h1C, 32'h8000_003F);
        rd_chk("R9 unmapped",    8'hD0, 0);
        rd_chk("R9 unmapped top", 8'hFC, 0);
        rd_chk("R9 unaligned",   8'h05, 0);
        hp_result = 32'h8005_0003;
        rd_chk("R11 result", 8'h18, 32'h8005_0003);
    endtask

    task automatic t_rereset();
        wr(8'h08, 32'hFF); wr(8'h14, 1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_chk("R10 class0 cleared", 8'h08, 0);
        rd_chk("R10 ctrl cleared",   8'h14, 0);
        rd_chk("R10 entry39 cleared", 8'hCC, 0);
        rd_chk("R10 mask0 cleared",  8'h04, 0);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mapping();
        t_views();
        t_wake();
        t_prio();
        t_readonly();
        t_rereset();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            report();
        end
    end

endmodule